// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 52-bit physical address by reading a four-level radix translation tree out of memory, one entry per level. A requester hands over the address, whether the access is a read or a write, and whether it runs in user or supervisor mode. A separate input gives the physical base of the top-level table. The walker returns either the translated physical address or a fault, with a cause code and the level at which the walk stopped.

Every entry access goes through one request/response memory port. Each access is a 64-bit read or write, and every request gets exactly one response pulse. On the way down, the walker checks the present, user and writable bits of each entry. It also marks entries as accessed and, for writes, marks the final entry as dirty. To do this it writes the updated entry back before it moves to the next level. Only one translation is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: If bits 63 down to 47 of the request address are not all equal, the walk ends with fault=1, cause 0 and level 0, and issues no memory request.
- R2: The entry read at step k (k=1..4) is at the table base joined with {index_k, 3'b000}. Index_1 is taken from address bits 47:39, index_2 from 38:30, index_3 from 29:21 and index_4 from 20:12. The first table base is `root_base[51:12]`, used untranslated. Each later base is bits 51:12 of the entry just read.
- R3: A successful walk returns fault=0 and physical address {bits 51:12 of the last entry, address bits 11:0}.
- R4: An entry whose bit 0 (present) is clear ends the walk with cause 1. The level output gives the level of that entry, from 1 to 4.
- R5: A user access to an entry whose bit 2 (user) is clear ends the walk with cause 2. This check applies at every level.
- R6: A write to an entry whose bit 1 (writable) is clear ends the walk with cause 3. This check applies at every level.
- R7: When several checks fail on one entry, the cause is chosen in this order: not present first, then privilege, then write-protect.
- R8: An entry that passes its checks but has bit 5 (accessed) clear is written back with bit 5 set, before the next read is issued. An entry whose bits do not change is not written. A faulting entry is never written.
- R9: On a write access, the last-level entry is written back with bit 6 (dirty) set. Entries above the last level never get bit 6 set.
- R10: `req_ready` is high only while idle. It stays low from the accepting edge until the result has been taken with `rsp_valid && rsp_ready`.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response outputs hold their values.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request (address, write flag, write data) holds. Each accepted memory request is finished by one `mem_rsp_valid` pulse, which carries the read data for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| root_base | input | 52 | Physical address of the top-level table |
| mem_req_valid | output | 1 | Entry access request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_req_wdata | output | 64 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | One-cycle completion of a memory request |
| mem_rsp_rdata | input | 64 | Entry data for a read |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | 1 = walk faulted |
| rsp_cause | output | 2 | Fault cause: 0 non-canonical, 1 not present, 2 privilege, 3 write-protect |
| rsp_level | output | 3 | Level (1..4) of the faulting entry, 0 for a non-canonical address |
| rsp_paddr | output | 52 | Translated physical address when no fault |

## Verification
A corrupted level counter or table base shows up at the memory port on the very next entry request, as an address outside the expected table slot. It also shows up at the result port as a wrong level or physical page. Wrong permission decoding shows up in the cause code of the same walk. Errors in the write-back decision are only visible as extra, missing or mis-valued entry writes. The bench therefore counts reads and writes per walk and inspects the stored entries right after the result is returned. Handshake faults, such as a request dropped during a stall or ready raised while busy, appear within one cycle of the stall or of acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry flag positions that the walk decodes.
  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;
  localparam int FLAG_ACCESS  = 5;
  localparam int FLAG_DIRTY   = 6;

  typedef enum logic [1:0] {
    CAUSE_NONCANON   = 2'd0,
    CAUSE_NOTPRESENT = 2'd1,
    CAUSE_PRIV       = 2'd2,
    CAUSE_WRPROT     = 2'd3
  } walk_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_EVAL    = 3'd3,
    ST_WR_REQ  = 3'd4,
    ST_WR_WAIT = 3'd5,
    ST_DONE    = 3'd6
  } walk_state_e;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk #(
  parameter int VA_W  = 64,
  parameter int SIG_W = 48
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            canonical
);

  localparam int EXT_W = VA_W - SIG_W + 1;

  logic [EXT_W-1:0] ext_bits;

  // Bits above the significant range must replicate its top bit.
  assign ext_bits  = vaddr[VA_W-1:SIG_W-1];
  assign canonical = (&ext_bits) | ~(|ext_bits);

endmodule

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int VA_W   = 64,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int STEP_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [STEP_W-1:0] step,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] slice [LEVELS];

  // Step 0 uses the most significant index field.
  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign slice[l] = vaddr[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
  end

  assign idx = slice[step];

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PA_W  = 52,
  parameter int OFF_W = 12,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic             is_user,
  input  logic             is_last,
  output logic             fault,
  output walk_cause_e      cause,
  output logic [PTE_W-1:0] pte_upd,
  output logic             need_wb,
  output logic [PPN_W-1:0] ppn
);

  assign ppn = pte[PA_W-1:OFF_W];

  // Checks in priority order: presence, privilege, write permission.
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_NOTPRESENT;
    if (!pte[FLAG_PRESENT]) begin
      fault = 1'b1;
      cause = CAUSE_NOTPRESENT;
    end else if (is_user && !pte[FLAG_USER]) begin
      fault = 1'b1;
      cause = CAUSE_PRIV;
    end else if (is_write && !pte[FLAG_WRITE]) begin
      fault = 1'b1;
      cause = CAUSE_WRPROT;
    end
  end

  always_comb begin
    pte_upd               = pte;
    pte_upd[FLAG_ACCESS]  = 1'b1;
    if (is_last && is_write) pte_upd[FLAG_DIRTY] = 1'b1;
  end

  assign need_wb = (pte_upd != pte);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int SIG_W  = 48,
  parameter int PA_W   = 52,
  parameter int PTE_W  = 64,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int STEP_W = $clog2(LEVELS),
  localparam int LVL_W  = $clog2(LEVELS + 1),
  localparam int ENT_SH = $clog2(PTE_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [PA_W-1:0]   root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [LVL_W-1:0]  rsp_level,
  output logic [PA_W-1:0]   rsp_paddr
);

  logic rst_n_sync;

  ptw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // ---------------------------------------------------------------
  // State and context registers
  // ---------------------------------------------------------------
  walk_state_e       state_q, state_d;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, usr_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic [PPN_W-1:0]  base_q, base_d;
  logic [PTE_W-1:0]  pte_q, pte_d;
  logic              fault_q, fault_d;
  walk_cause_e       cause_q, cause_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic [PA_W-1:0]   paddr_q, paddr_d;

  logic ctx_en;
  logic walk_en;
  logic advance;
  logic last_step;

  // ---------------------------------------------------------------
  // Address checking and index selection
  // ---------------------------------------------------------------
  logic             req_canon;
  logic [IDX_W-1:0] cur_idx;

  ptw_canon_chk #(.VA_W(VA_W), .SIG_W(SIG_W)) u_canon (
    .vaddr     (req_vaddr),
    .canonical (req_canon)
  );

  ptw_idx_sel #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_idx (
    .vaddr (va_q),
    .step  (step_q),
    .idx   (cur_idx)
  );

  // ---------------------------------------------------------------
  // Entry evaluation
  // ---------------------------------------------------------------
  logic             ev_fault;
  walk_cause_e      ev_cause;
  logic [PTE_W-1:0] ev_upd;
  logic             ev_wb;
  logic [PPN_W-1:0] ev_ppn;

  assign last_step = (step_q == STEP_W'(LEVELS - 1));

  ptw_pte_eval #(.PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_eval (
    .pte      (pte_q),
    .is_write (wr_q),
    .is_user  (usr_q),
    .is_last  (last_step),
    .fault    (ev_fault),
    .cause    (ev_cause),
    .pte_upd  (ev_upd),
    .need_wb  (ev_wb),
    .ppn      (ev_ppn)
  );

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    base_d  = base_q;
    pte_d   = pte_q;
    fault_d = fault_q;
    cause_d = cause_q;
    level_d = level_q;
    paddr_d = paddr_q;
    advance = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          step_d  = '0;
          base_d  = root_base[PA_W-1:OFF_W];
          fault_d = 1'b0;
          cause_d = CAUSE_NONCANON;
          level_d = '0;
          paddr_d = '0;
          if (!req_canon) begin
            fault_d = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_RD_REQ;
          end
        end
      end
      ST_RD_REQ: begin
        if (mem_req_ready) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          pte_d   = mem_rsp_rdata;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (ev_fault) begin
          fault_d = 1'b1;
          cause_d = ev_cause;
          level_d = LVL_W'(step_q) + LVL_W'(1);
          state_d = ST_DONE;
        end else if (ev_wb) begin
          pte_d   = ev_upd;
          state_d = ST_WR_REQ;
        end else begin
          advance = 1'b1;
        end
      end
      ST_WR_REQ: begin
        if (mem_req_ready) state_d = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (mem_rsp_valid) advance = 1'b1;
      end
      ST_DONE: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (advance) begin
      if (last_step) begin
        paddr_d = {ev_ppn, va_q[OFF_W-1:0]};
        state_d = ST_DONE;
      end else begin
        base_d  = ev_ppn;
        step_d  = step_q + STEP_W'(1);
        state_d = ST_RD_REQ;
      end
    end
  end

  assign ctx_en  = (state_q == ST_IDLE) && req_valid;
  assign walk_en = (state_q != ST_DONE);

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      va_q  <= '0;
      wr_q  <= 1'b0;
      usr_q <= 1'b0;
    end else if (ctx_en) begin
      va_q  <= req_vaddr;
      wr_q  <= req_write;
      usr_q <= req_user;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      step_q  <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONCANON;
      level_q <= '0;
      paddr_q <= '0;
    end else if (walk_en) begin
      step_q  <= step_d;
      base_q  <= base_d;
      pte_q   <= pte_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
      level_q <= level_d;
      paddr_q <= paddr_d;
    end
  end

  // ---------------------------------------------------------------
  // Outputs
  // ---------------------------------------------------------------
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_addr  = {base_q, OFF_W'({cur_idx, ENT_SH'(0)})};
  assign mem_req_wdata = pte_q;

  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_fault = fault_q;
  assign rsp_cause = cause_q;
  assign rsp_level = level_q;
  assign rsp_paddr = paddr_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  p_noncanon_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_ready && !req_canon) |=> (!mem_req_valid && rsp_valid && rsp_fault));

  p_root_first_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_ready && req_canon) |=>
      (mem_req_valid && !mem_req_write &&
       mem_req_addr[PA_W-1:OFF_W] == $past(root_base[PA_W-1:OFF_W])));

  p_fault_level_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rsp_valid && rsp_fault && rsp_cause != 2'd0) |->
      (rsp_level >= LVL_W'(1) && rsp_level <= LVL_W'(LEVELS)));

  p_wb_marks_access_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_req_valid && mem_req_write) |->
      (mem_req_wdata[FLAG_ACCESS] && mem_req_wdata[FLAG_PRESENT]));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_req_valid || rsp_valid) |-> !req_ready);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_fault) && $stable(rsp_cause) &&
       $stable(rsp_level) && $stable(rsp_paddr)));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 14;

  localparam logic [11:0] FP = 12'h001;
  localparam logic [11:0] FW = 12'h002;
  localparam logic [11:0] FU = 12'h004;
  localparam logic [11:0] FA = 12'h020;

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic        usr;
    logic        flt;
    logic [1:0]  cause;
    logic [2:0]  lvl;
    logic [51:0] pa;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [51:0] first;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{64'h0000_0000_0020_5123, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 52'hA_BCDE_123, 4'd4, 4'd4, 52'h1000},
    '{64'h0000_0000_0020_5123, 1'b1, 1'b1, 1'b1, 2'd3, 3'd4, 52'h0,          4'd4, 4'd3, 52'h1000},
    '{64'h0000_0000_0020_6FF8, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 52'h1_2345_FF8, 4'd4, 4'd4, 52'h1000},
    '{64'h0000_0000_0020_7000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd4, 52'h0,          4'd4, 4'd3, 52'h1000},
    '{64'h0000_0000_0020_8010, 1'b0, 1'b1, 1'b1, 2'd2, 3'd4, 52'h0,          4'd4, 4'd3, 52'h1000},
    '{64'h0000_0000_0020_8010, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 52'h77_7010,    4'd4, 4'd4, 52'h1000},
    '{64'h0000_0000_0020_9000, 1'b1, 1'b1, 1'b1, 2'd2, 3'd4, 52'h0,          4'd4, 4'd3, 52'h1000},
    '{64'h0000_0000_0040_0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd3, 52'h0,          4'd3, 4'd2, 52'h1000},
    '{64'h0000_0080_0000_0000, 1'b0, 1'b1, 1'b1, 2'd2, 3'd1, 52'h0,          4'd1, 4'd0, 52'h1008},
    '{64'h0000_0080_0000_0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 52'h0,          4'd2, 4'd1, 52'h1008},
    '{64'hFFFF_8000_0000_0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd1, 52'h0,          4'd1, 4'd0, 52'h1800},
    '{64'h0001_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 52'h0,          4'd0, 4'd0, 52'h0},
    '{64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 2'd0, 3'd0, 52'h0,          4'd0, 4'd0, 52'h0},
    '{64'h0000_0100_0000_0000, 1'b1, 1'b1, 1'b1, 2'd3, 3'd1, 52'h0,          4'd1, 4'd0, 52'h1010}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic        req_write;
  logic        req_user;
  logic [51:0] root_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_rdata;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [2:0]  rsp_level;
  logic [51:0] rsp_paddr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .req_user      (req_user),
    .root_base     (root_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_level     (rsp_level),
    .rsp_paddr     (rsp_paddr)
  );

  // ---------------- memory model: pages 0..7, one response per request
  logic [63:0] mem [0:4095];
  int          n_rd, n_wr;
  logic [51:0] first_addr;
  logic        stall_en;
  logic [7:0]  cyc;

  assign mem_req_ready = !stall_en || cyc[1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      cyc           <= '0;
    end else begin
      cyc           <= cyc + 8'd1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_write) begin
          mem[mem_req_addr[14:3]] <= mem_req_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rsp_rdata <= mem[mem_req_addr[14:3]];
          if (n_rd == 0) first_addr <= mem_req_addr;
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  function automatic logic [63:0] mk_pte(logic [39:0] ppn, logic [11:0] flags);
    return {12'h000, ppn, flags};
  endfunction

  function automatic logic [11:0] slot(int page, int idx);
    return {page[2:0], idx[8:0]};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 4096; i++) mem[i] <= '0;
    mem[slot(1, 0)]   <= mk_pte(40'h2, FP | FW | FU);
    mem[slot(1, 1)]   <= mk_pte(40'h5, FP | FW);
    mem[slot(1, 2)]   <= mk_pte(40'h6, FP | FU);
    mem[slot(2, 0)]   <= mk_pte(40'h3, FP | FW | FU);
    mem[slot(3, 1)]   <= mk_pte(40'h4, FP | FW | FU);
    mem[slot(4, 5)]   <= mk_pte(40'hABCDE, FP | FU);
    mem[slot(4, 6)]   <= mk_pte(40'h12345, FP | FW | FU | FA);
    mem[slot(4, 8)]   <= mk_pte(40'h777, FP | FW);
    mem[slot(4, 9)]   <= mk_pte(40'h888, FP);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic        got_fault;
  logic [1:0]  got_cause;
  logic [2:0]  got_level;
  logic [51:0] got_paddr;

  task automatic run_walk(logic [63:0] va, logic wr, logic usr, int hold);
    bit busy_ready;
    busy_ready = 1'b0;
    @(negedge clk);
    n_rd      <= 0;
    n_wr      <= 0;
    first_addr <= '0;
    req_vaddr <= va;
    req_write <= wr;
    req_user  <= usr;
    req_valid <= 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid <= 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_ready = 1'b1;
      @(negedge clk);
    end
    got_fault = rsp_fault;
    got_cause = rsp_cause;
    got_level = rsp_level;
    got_paddr = rsp_paddr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (req_ready) busy_ready = 1'b1;
    end
    chk("R11 held response", {rsp_valid, rsp_fault, rsp_cause, rsp_level, rsp_paddr},
        {1'b1, got_fault, got_cause, got_level, got_paddr});
    chk("R10 ready low while busy", {63'd0, busy_ready}, 64'd0);
    rsp_ready <= 1'b1;
    @(negedge clk);
    rsp_ready <= 1'b0;
    chk("R10 ready back after handshake", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10 watchdog: actual=hung expected=response");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_write = 1'b0;
    req_user  = 1'b0;
    rsp_ready = 1'b0;
    root_base = 52'h1000;
    stall_en  = 1'b0;
    n_rd      = 0;
    n_wr      = 0;
    first_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R10 reset req_ready", {63'd0, req_ready}, 64'd1);
    chk("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R12 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NVEC; i++) begin
      init_mem();
      stall_en <= i[0];
      run_walk(VECS[i].va, VECS[i].wr, VECS[i].usr, 1 + (i % 3));
      chk($sformatf("R1 R4 R5 R6 R7 fault flag vec %0d", i), {63'd0, got_fault}, {63'd0, VECS[i].flt});
      if (VECS[i].flt) begin
        chk($sformatf("R1 R4 R5 R6 R7 cause vec %0d", i), {62'd0, got_cause}, {62'd0, VECS[i].cause});
        chk($sformatf("R1 R4 level vec %0d", i), {61'd0, got_level}, {61'd0, VECS[i].lvl});
      end else begin
        chk($sformatf("R3 paddr vec %0d", i), {12'd0, got_paddr}, {12'd0, VECS[i].pa});
      end
      chk($sformatf("R2 R12 entry reads vec %0d", i), 64'(n_rd), 64'(VECS[i].nrd));
      chk($sformatf("R8 R9 entry writes vec %0d", i), 64'(n_wr), 64'(VECS[i].nwr));
      if (VECS[i].nrd != 0)
        chk($sformatf("R2 first entry address vec %0d", i), {12'd0, first_addr}, {12'd0, VECS[i].first});
    end
    stall_en <= 1'b0;

    // R8: accessed bits set on the used path, not dirty on a read
    init_mem();
    run_walk(64'h20_5123, 1'b0, 1'b1, 0);
    chk("R8 leaf accessed set", {63'd0, mem[slot(4, 5)][5]}, 64'd1);
    chk("R8 root accessed set", {63'd0, mem[slot(1, 0)][5]}, 64'd1);
    chk("R9 leaf not dirty on read", {63'd0, mem[slot(4, 5)][6]}, 64'd0);
    // R8: repeating the walk changes nothing, so nothing is written
    run_walk(64'h20_5123, 1'b0, 1'b1, 0);
    chk("R8 no write when unchanged", 64'(n_wr), 64'd0);
    chk("R3 repeat paddr", {12'd0, got_paddr}, 64'hA_BCDE_123);

    // R9: write sets dirty only on the last level
    init_mem();
    run_walk(64'h20_6FF8, 1'b1, 1'b1, 0);
    chk("R9 leaf dirty set", {63'd0, mem[slot(4, 6)][6]}, 64'd1);
    chk("R9 upper entry not dirty", {63'd0, mem[slot(3, 1)][6]}, 64'd0);
    chk("R9 leaf entry ppn kept", mem[slot(4, 6)], mk_pte(40'h12345, FP | FW | FU | FA | 12'h040));

    // R8: a faulting entry is left untouched
    init_mem();
    run_walk(64'h20_5123, 1'b1, 1'b1, 0);
    chk("R8 faulting entry unwritten", mem[slot(4, 5)], mk_pte(40'hABCDE, FP | FU));

    // R2: a different root base relocates the first read
    init_mem();
    root_base <= 52'h7000;
    mem[slot(7, 0)] <= mk_pte(40'h2, FP | FW | FU | FA);
    run_walk(64'h20_5123, 1'b0, 1'b1, 0);
    chk("R2 relocated root address", {12'd0, first_addr}, 64'h7000);
    chk("R3 paddr via relocated root", {12'd0, got_paddr}, 64'hA_BCDE_123);

    finish_run();
  end

endmodule